// File: doc/BRIEF.md
# Four-Phase Handshake Sequencer

This block is a control element for handshake-driven datapaths. It has one passive channel, through which a controller starts it, and two active channels, through which it starts two downstream tasks in turn. Each channel is a request wire and an acknowledge wire that return to zero.

A rising start request makes the block run one full cycle on the first task channel: raise its request, wait for its acknowledge, drop the request, and wait for the acknowledge to fall. It then raises the second task's request. Once that acknowledge is high, the block acknowledges the start channel. The return-to-zero of the second task is folded into the start channel's release. When the start request drops, the block lowers the second request, waits for its acknowledge to fall, and only then drops the start acknowledge. The second task's handshake therefore spans both halves of the activating handshake.

The block is a clocked state machine. All three incoming wires pass through a parameterised synchronizer before the state machine samples them. Every output comes straight from a flop.

Top module: `seq4_hs_sequencer`

## Requirements
- R1: While `rst_n` is low, all three outputs are low, and they go low without waiting for a clock edge. After reset is released with all inputs low, the outputs stay low until `act_req` rises.
- R2: `first_req` rises only after `act_req` has risen while `act_ack` is low. Events on all six wires follow one fixed order per activation: act_req rise, first_req rise, first_ack rise, first_req fall, first_ack fall, second_req rise, second_ack rise, act_ack rise, act_req fall, second_req fall, second_ack fall, act_ack fall.
- R3: `first_req` falls only after `first_ack` has been seen high.
- R4: `second_req` rises only after `first_ack` has been seen low again while `first_req` is low.
- R5: `act_ack` rises only after `second_ack` has been seen high while `second_req` is still high.
- R6: `second_req` falls only after `act_req` has been seen low while `act_ack` is high.
- R7: `act_ack` falls only after `second_ack` has been seen low while `second_req` is low. Each activation then leaves the block idle with no pending events.
- R8: In any clock cycle, at most one of the three outputs changes.
- R9: `first_req` and `second_req` are never high together.
- R10: An input transition that the current protocol step is not waiting for has no effect. For example, a pulse on `second_ack` while the first task's request is outstanding leaves `first_req` high and both `second_req` and `act_ack` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| act_req | input | 1 | Start request from the activating controller |
| act_ack | output | 1 | Start acknowledge to the activating controller |
| first_req | output | 1 | Request to the first task |
| first_ack | input | 1 | Acknowledge from the first task |
| second_req | output | 1 | Request to the second task |
| second_ack | input | 1 | Acknowledge from the second task |

## Verification
The bench runs many activations in which both task partners answer after random delays of zero to four cycles and the start controller pauses randomly. Every transition on all six wires is compared with the required order. This separates a correct design from one that acknowledges the start channel early, or that returns the second task to zero before the start request falls. In a directed run the first task is held unanswered while a stray pulse arrives on the second acknowledge, which tests whether the state machine really ignores inputs it is not waiting for. A reset asserted in the middle of an activation shows that the outputs clear at once and that the block starts cleanly afterwards.

// File: rtl/seq4_pkg.sv
package seq4_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FIRST_H = 3'd1,
    ST_FIRST_L = 3'd2,
    ST_SECOND  = 3'd3,
    ST_ACKED   = 3'd4,
    ST_RELEASE = 3'd5
  } seq_state_t;
endpackage

// File: rtl/seq4_rst_sync.sv
module seq4_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/seq4_in_sync.sv
module seq4_in_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= din;
          end
        end else begin : g_next
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
          end
        end
      end
      assign dout = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/seq4_fsm.sv
module seq4_fsm
  import seq4_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic act_req_s,
  input  logic first_ack_s,
  input  logic second_ack_s,
  output logic act_ack_q,
  output logic first_req_q,
  output logic second_req_q
);
  seq_state_t state_q, state_d;
  logic       step_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (act_req_s)     state_d = ST_FIRST_H;
      ST_FIRST_H: if (first_ack_s)   state_d = ST_FIRST_L;
      ST_FIRST_L: if (!first_ack_s)  state_d = ST_SECOND;
      ST_SECOND:  if (second_ack_s)  state_d = ST_ACKED;
      ST_ACKED:   if (!act_req_s)    state_d = ST_RELEASE;
      ST_RELEASE: if (!second_ack_s) state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  assign step_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      first_req_q  <= 1'b0;
      second_req_q <= 1'b0;
      act_ack_q    <= 1'b0;
    end else if (step_en) begin
      state_q      <= state_d;
      first_req_q  <= (state_d == ST_FIRST_H);
      second_req_q <= (state_d == ST_SECOND) || (state_d == ST_ACKED);
      act_ack_q    <= (state_d == ST_ACKED) || (state_d == ST_RELEASE);
    end
  end

  a_r2_first_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(first_req_q) |-> $past(act_req_s) && !$past(act_ack_q));
  a_r3_first_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(first_req_q) |-> $past(first_ack_s));
  a_r4_second_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(second_req_q) |-> !$past(first_ack_s) && !first_req_q);
  a_r5_ack_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_ack_q) |-> $past(second_ack_s) && second_req_q);
  a_r6_second_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(second_req_q) |-> !$past(act_req_s) && act_ack_q);
  a_r7_ack_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_ack_q) |-> !$past(second_ack_s) && !second_req_q);
  a_r8_one_change: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!$stable(act_ack_q), !$stable(first_req_q),
                !$stable(second_req_q)}) <= 1);
  a_r9_req_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(first_req_q && second_req_q));
endmodule

// File: rtl/seq4_hs_sequencer.sv
module seq4_hs_sequencer #(
  parameter int RST_STAGES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_req,
  output logic act_ack,
  output logic first_req,
  input  logic first_ack,
  output logic second_req,
  input  logic second_ack
);
  localparam int NUM_IN = 3;

  logic              rst_int_n;
  logic [NUM_IN-1:0] raw_in, sync_in;

  seq4_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign raw_in = {second_ack, first_ack, act_req};

  seq4_in_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (raw_in),
    .dout  (sync_in)
  );

  seq4_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .act_req_s    (sync_in[0]),
    .first_ack_s  (sync_in[1]),
    .second_ack_s (sync_in[2]),
    .act_ack_q    (act_ack),
    .first_req_q  (first_req),
    .second_req_q (second_req)
  );

  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |-> !act_ack && !first_req && !second_req);
endmodule

// File: tb/tb_seq4_hs_sequencer.sv
module tb_seq4_hs_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int N_ACT      = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic act_req;
  logic act_ack, first_req, second_req;
  logic first_ack_env, second_ack_env, second_glitch;
  logic first_ack, second_ack;
  logic first_hold;
  logic mon_on;
  logic [5:0] cur, prev;
  int exp_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign first_ack  = first_ack_env;
  assign second_ack = second_ack_env | second_glitch;

  seq4_hs_sequencer dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_req    (act_req),
    .act_ack    (act_ack),
    .first_req  (first_req),
    .first_ack  (first_ack),
    .second_req (second_req),
    .second_ack (second_ack)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int e);
    case (e)
      5:       return "R2";
      4:       return "R3";
      9:       return "R4";
      3:       return "R5";
      8:       return "R6";
      2:       return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Partner of the first task: echoes its request after a random delay
  initial begin
    first_ack_env = 1'b0;
    forever begin
      @(negedge clk);
      if (!first_hold && first_req != first_ack_env) begin
        int d;
        d = $urandom_range(0, 4);
        repeat (d) @(negedge clk);
        #1 first_ack_env = first_req;
      end
    end
  end

  // Partner of the second task
  initial begin
    second_ack_env = 1'b0;
    forever begin
      @(negedge clk);
      if (second_req != second_ack_env) begin
        int d;
        d = $urandom_range(0, 4);
        repeat (d) @(negedge clk);
        #1 second_ack_env = second_req;
      end
    end
  end

  // Monitor: compares each wire transition against the scoreboard
  always @(negedge clk) begin
    cur = {second_ack, second_req, first_ack, first_req, act_ack, act_req};
    if (mon_on) begin
      for (int i = 0; i < 6; i++) begin
        if (cur[i] != prev[i]) begin
          int got;
          got = i * 2 + int'(cur[i]);
          if (exp_q.size() == 0) begin
            check(1'b0, "R2", got, -1);
          end else begin
            int e;
            e = exp_q.pop_front();
            check(got == e, tag_of(e), got, e);
          end
          if (i == 1 || i == 2 || i == 4)
            check(!(first_req && second_req), "R9", int'(first_req && second_req), 0);
        end
      end
      if ((cur[1] != prev[1]) + (cur[2] != prev[2]) + (cur[4] != prev[4]) > 0)
        check(((cur[1] != prev[1]) + (cur[2] != prev[2]) + (cur[4] != prev[4])) <= 1,
              "R8", (cur[1] != prev[1]) + (cur[2] != prev[2]) + (cur[4] != prev[4]), 1);
    end
    prev = cur;
  end

  task automatic activate();
    int d;
    exp_q.push_back(1);  exp_q.push_back(5);  exp_q.push_back(7);
    exp_q.push_back(4);  exp_q.push_back(6);  exp_q.push_back(9);
    exp_q.push_back(11); exp_q.push_back(3);  exp_q.push_back(0);
    exp_q.push_back(8);  exp_q.push_back(10); exp_q.push_back(2);
    d = $urandom_range(0, 3);
    repeat (d) @(negedge clk);
    #1 act_req = 1'b1;
    wait (act_ack);
    @(negedge clk);
    d = $urandom_range(0, 3);
    repeat (d) @(negedge clk);
    #1 act_req = 1'b0;
    wait (!act_ack);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    act_req = 1'b0;
    second_glitch = 1'b0;
    first_hold = 1'b0;
    mon_on = 1'b0;
    repeat (4) @(negedge clk);
    check(!act_ack && !first_req && !second_req, "R1",
          {act_ack, first_req, second_req}, 0);
    #1 rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(!act_ack && !first_req && !second_req, "R1",
          {act_ack, first_req, second_req}, 0);
    mon_on = 1'b1;

    for (int k = 0; k < N_ACT; k++) activate();
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);

    // Stray second-task acknowledge while the first task is outstanding
    mon_on = 1'b0;
    first_hold = 1'b1;
    #1 act_req = 1'b1;
    wait (first_req);
    @(negedge clk);
    #1 second_glitch = 1'b1;
    repeat (4) @(negedge clk);
    check(!second_req && !act_ack, "R10", {second_req, act_ack}, 0);
    #1 second_glitch = 1'b0;
    repeat (6) @(negedge clk);
    check(first_req && !second_req && !act_ack, "R10",
          {first_req, second_req, act_ack}, 3'b100);
    first_hold = 1'b0;
    wait (act_ack);
    @(negedge clk);
    #1 act_req = 1'b0;
    wait (!act_ack);
    repeat (8) @(negedge clk);
    check(!first_req && !second_req && !act_ack, "R10",
          {first_req, second_req, act_ack}, 0);

    // Reset in the middle of an activation
    #1 act_req = 1'b1;
    wait (second_req);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check(!act_ack && !first_req && !second_req, "R1",
             {act_ack, first_req, second_req}, 0);
    act_req = 1'b0;
    wait (!first_ack && !second_ack);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check(!act_ack && !first_req && !second_req, "R1",
          {act_ack, first_req, second_req}, 0);

    exp_q.delete();
    @(negedge clk);
    mon_on = 1'b1;
    for (int k = 0; k < 10; k++) activate();
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);
    summary();
  end
endmodule